// File: doc/BRIEF.md
# Dual-Function 8-Bit GPIO Port

This block controls one 8-bit bidirectional I/O port in a small microcontroller. A simple register bus reaches three registers: the port address, which reads the pin levels after synchronization; the output latch; and the direction mask. Each pin's output value and driver enable are steered to the pad ring. Tri-state pads, analog circuits and the memory controller stay outside the block. They appear only as signals.

Each half of the port can be handed to an alternate function. A configuration input controls each half, and while that input is low the alternate function is active. The upper four pins become analog converter inputs. Their drivers are released and they read back as zero. The lower four pins carry address bits 19..16 of an external memory bus, which the block takes from an input. The direction and latch registers keep their values while a half is taken over. Those values return to the pins once the half goes back to general I/O.

Top module: `gpio_mux_port`

## Requirements
- R1: A synchronous active-high reset sets the direction register to 8'hFF (all pins inputs) and clears the output latch to 8'h00.
- R2: A write strobe at address 0 (port) or address 1 (latch) loads bus_wdata into the output latch on the next rising clock edge.
- R3: A write strobe at address 2 (direction) loads bus_wdata into the direction register on the next rising clock edge. A 1 bit means input and a 0 bit means output.
- R4: A read of address 1 returns the latch contents, whatever the pin levels are.
- R5: A read of address 0 returns each pin level as it was sampled two rising edges earlier (two-flop synchronizer).
- R6: While hi_io_en is 0 (analog mode, bits 7..4):
  - pin_oe[7:4] and pin_out[7:4] are 0;
  - ana_sel[7:4] is 4'hF;
  - a port read returns 0 in bits 7..4.
- R7: While hi_io_en is 1, bits 7..4 work as I/O: pin_oe is the inverse of the direction bits, pin_out equals the latch bits, and ana_sel[7:4] is 0. ana_sel[3:0] is always 0.
- R8: While lo_io_en is 0 (bus mode, bits 3..0), pin_oe[3:0] is 4'hF and pin_out[3:0] equals ext_addr.
- R9: While lo_io_en is 1, pin_oe[3:0] is the inverse of the direction bits and pin_out[3:0] equals the latch bits.
- R10: Writes made during analog or bus mode still update the latch and direction registers without reaching the taken-over pins. The registers hold when no write strobe is given, and the stored values appear on the pins once the half returns to I/O mode.
- R11: bus_rdata is 0 when bus_rd is low or when address 3 (unused) is read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 port, 1 latch, 2 direction, 3 unused |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| hi_io_en | input | 1 | 1: bits 7..4 are general I/O; 0: analog inputs |
| lo_io_en | input | 1 | 1: bits 3..0 are general I/O; 0: external address bus |
| ext_addr | input | 4 | External memory address bits 19..16 |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_out | output | 8 | Per-pin output value |
| pin_oe | output | 8 | Per-pin driver enable, 1 drives |
| ana_sel | output | 8 | Per-pin analog-input select |

## Verification
The reference model is compared against the design on every cycle. Fixed patterns come first, with the pin level chosen to differ from the latch so that a latch read can be told apart from a port read. The same data value is written through both the port address and the latch address, which shows that both reach the same register. An external address that differs from the latch shows that bus mode selects its own source. With the pins held at all ones in analog mode, any leak of the upper nibble into a port read would show. A long run then randomizes addresses, strobes, data, pin levels, ext_addr and both mode inputs, so that mode changes coincide with writes and reads.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

    localparam int PORT_W = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        RA_PORT  = 2'd0,
        RA_LATCH = 2'd1,
        RA_DIR   = 2'd2,
        RA_NONE  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic ld_latch;
        logic ld_dir;
    } wr_sel_t;

    // Port and latch addresses both land in the output latch.
    function automatic wr_sel_t decode_wr(input logic wr, input reg_addr_e a);
        wr_sel_t s;
        s.ld_latch = wr && (a == RA_PORT || a == RA_LATCH);
        s.ld_dir   = wr && (a == RA_DIR);
        return s;
    endfunction

endpackage

// File: rtl/gpio_mux_regs.sv
module gpio_mux_regs #(
    parameter int W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  gpio_mux_pkg::wr_sel_t    sel,
    input  logic [W-1:0]             wdata,
    output logic [W-1:0]             lat_q,
    output logic [W-1:0]             dir_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
            dir_q <= '1;
        end else begin
            if (sel.ld_latch) lat_q <= wdata;
            if (sel.ld_dir)   dir_q <= wdata;
        end
    end
endmodule

// File: rtl/gpio_mux_sync.sv
module gpio_mux_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_mux_nibble.sv
// Pad steering for one half of the port. ALT_DRIVES picks the alternate
// function: 1 = block drives alt_val (address bus), 0 = analog input.
module gpio_mux_nibble #(
    parameter int W          = 4,
    parameter bit ALT_DRIVES = 1'b0
) (
    input  logic         io_en,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] lat,
    input  logic [W-1:0] alt_val,
    input  logic [W-1:0] sync_pin,
    output logic [W-1:0] out,
    output logic [W-1:0] oe,
    output logic [W-1:0] rd_val,
    output logic [W-1:0] ana
);
    assign out = io_en ? lat : alt_val;

    generate
        if (ALT_DRIVES) begin : g_bus
            assign oe     = io_en ? ~dir : '1;
            assign rd_val = sync_pin;
            assign ana    = '0;
        end else begin : g_analog
            assign oe     = io_en ? ~dir : '0;
            assign rd_val = io_en ? sync_pin : '0;
            assign ana    = io_en ? '0 : '1;
        end
    endgenerate
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port #(
    parameter int PORT_W = gpio_mux_pkg::PORT_W,
    parameter int ADDR_W = gpio_mux_pkg::ADDR_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [PORT_W-1:0]   bus_wdata,
    output logic [PORT_W-1:0]   bus_rdata,
    input  logic                hi_io_en,
    input  logic                lo_io_en,
    input  logic [PORT_W/2-1:0] ext_addr,
    input  logic [PORT_W-1:0]   pin_in,
    output logic [PORT_W-1:0]   pin_out,
    output logic [PORT_W-1:0]   pin_oe,
    output logic [PORT_W-1:0]   ana_sel
);
    import gpio_mux_pkg::*;

    localparam int NIB_W = PORT_W / 2;

    reg_addr_e         addr_e;
    wr_sel_t           wsel;
    logic [PORT_W-1:0] lat_q;
    logic [PORT_W-1:0] dir_q;
    logic [PORT_W-1:0] pin_s;
    logic [PORT_W-1:0] port_val;

    assign addr_e = reg_addr_e'(bus_addr);
    assign wsel   = decode_wr(bus_wr, addr_e);

    gpio_mux_regs #(.W(PORT_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .sel   (wsel),
        .wdata (bus_wdata),
        .lat_q (lat_q),
        .dir_q (dir_q)
    );

    gpio_mux_sync #(.W(PORT_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_s)
    );

    // Lower half: external address bus alternate.
    gpio_mux_nibble #(.W(NIB_W), .ALT_DRIVES(1'b1)) u_lo (
        .io_en    (lo_io_en),
        .dir      (dir_q[NIB_W-1:0]),
        .lat      (lat_q[NIB_W-1:0]),
        .alt_val  (ext_addr),
        .sync_pin (pin_s[NIB_W-1:0]),
        .out      (pin_out[NIB_W-1:0]),
        .oe       (pin_oe[NIB_W-1:0]),
        .rd_val   (port_val[NIB_W-1:0]),
        .ana      (ana_sel[NIB_W-1:0])
    );

    // Upper half: analog input alternate.
    gpio_mux_nibble #(.W(PORT_W-NIB_W), .ALT_DRIVES(1'b0)) u_hi (
        .io_en    (hi_io_en),
        .dir      (dir_q[PORT_W-1:NIB_W]),
        .lat      (lat_q[PORT_W-1:NIB_W]),
        .alt_val  ('0),
        .sync_pin (pin_s[PORT_W-1:NIB_W]),
        .out      (pin_out[PORT_W-1:NIB_W]),
        .oe       (pin_oe[PORT_W-1:NIB_W]),
        .rd_val   (port_val[PORT_W-1:NIB_W]),
        .ana      (ana_sel[PORT_W-1:NIB_W])
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (addr_e)
                RA_PORT:  bus_rdata = port_val;
                RA_LATCH: bus_rdata = lat_q;
                RA_DIR:   bus_rdata = dir_q;
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk #(
    parameter int PORT_W = 8,
    parameter int ADDR_W = 2
) (
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [PORT_W-1:0]   bus_wdata,
    input logic [PORT_W-1:0]   bus_rdata,
    input logic                hi_io_en,
    input logic                lo_io_en,
    input logic [PORT_W/2-1:0] ext_addr,
    input logic [PORT_W-1:0]   pin_in,
    input logic [PORT_W-1:0]   pin_out,
    input logic [PORT_W-1:0]   pin_oe,
    input logic [PORT_W-1:0]   ana_sel,
    input logic [PORT_W-1:0]   lat_q,
    input logic [PORT_W-1:0]   dir_q
);
    localparam int NIB_W = PORT_W / 2;

    logic       rst_d = 1'b0;
    logic [1:0] up_cnt = 2'd0;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst)                up_cnt <= 2'd0;
        else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
    end

    p_reset_vals_r1: assert property (@(posedge clk)
        rst_d |-> (dir_q == '1 && lat_q == '0));

    p_latch_load_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (bus_addr == 2'd0 || bus_addr == 2'd1)) |=> (lat_q == $past(bus_wdata)));

    p_dir_load_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd2) |=> (dir_q == $past(bus_wdata)));

    p_sync_delay_r5: assert property (@(posedge clk) disable iff (rst)
        (up_cnt >= 2'd2 && bus_rd && bus_addr == 2'd0)
        |-> (bus_rdata[NIB_W-1:0] == $past(pin_in[NIB_W-1:0], 2)));

    p_analog_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !hi_io_en |-> (pin_oe[PORT_W-1:NIB_W] == '0 && ana_sel[PORT_W-1:NIB_W] == '1));

    p_bus_drive_r8: assert property (@(posedge clk) disable iff (rst)
        !lo_io_en |-> (pin_oe[NIB_W-1:0] == '1 && pin_out[NIB_W-1:0] == ext_addr));

    p_lo_io_dir_r9: assert property (@(posedge clk) disable iff (rst)
        lo_io_en |-> (pin_oe[NIB_W-1:0] == ~dir_q[NIB_W-1:0]));

    p_regs_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> ($stable(lat_q) && $stable(dir_q)));

    p_idle_read_r11: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == '0));
endmodule

bind gpio_mux_port gpio_mux_port_chk #(.PORT_W(PORT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .hi_io_en  (hi_io_en),
    .lo_io_en  (lo_io_en),
    .ext_addr  (ext_addr),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .ana_sel   (ana_sel),
    .lat_q     (lat_q),
    .dir_q     (dir_q)
);

// File: tb/gpio_mux_port_tb.sv
`timescale 1ns/1ps
module gpio_mux_port_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] bus_addr;
    logic       bus_wr, bus_rd;
    logic [7:0] bus_wdata, bus_rdata;
    logic       hi_io_en, lo_io_en;
    logic [3:0] ext_addr;
    logic [7:0] pin_in, pin_out, pin_oe, ana_sel;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;
    bit live  = 0;

    // behavioural reference state
    logic [7:0] m_dir = 8'hFF;
    logic [7:0] m_lat = 8'h00;
    logic [7:0] hist[$];

    always #5 clk = ~clk;

    gpio_mux_port u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hi_io_en(hi_io_en),
        .lo_io_en(lo_io_en), .ext_addr(ext_addr), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .ana_sel(ana_sel)
    );

    task automatic cmp(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_dir = 8'hFF;
            m_lat = 8'h00;
            hist  = '{8'h00, 8'h00};
            live  = 1;
        end else if (live) begin
            if (bus_wr && (bus_addr == 2'd0 || bus_addr == 2'd1)) m_lat = bus_wdata;
            if (bus_wr && bus_addr == 2'd2) m_dir = bus_wdata;
            hist.push_back(pin_in);
            void'(hist.pop_front());
        end
    end

    always @(negedge clk) begin
        if (live) begin
            logic [7:0] e_port, e_rd, e_oe, e_out, e_ana;
            string t_rd;
            e_port = {hi_io_en ? hist[0][7:4] : 4'h0, hist[0][3:0]};
            e_rd = 8'h00;
            t_rd = "R11";
            if (bus_rd) begin
                case (bus_addr)
                    2'd0: begin e_rd = e_port; t_rd = "R5 R6"; end
                    2'd1: begin e_rd = m_lat;  t_rd = "R2 R4"; end
                    2'd2: begin e_rd = m_dir;  t_rd = "R3"; end
                    default: begin e_rd = 8'h00; t_rd = "R11"; end
                endcase
            end
            e_oe[7:4]  = hi_io_en ? ~m_dir[7:4] : 4'h0;
            e_out[7:4] = hi_io_en ? m_lat[7:4]  : 4'h0;
            e_oe[3:0]  = lo_io_en ? ~m_dir[3:0] : 4'hF;
            e_out[3:0] = lo_io_en ? m_lat[3:0]  : ext_addr;
            e_ana      = {hi_io_en ? 4'h0 : 4'hF, 4'h0};
            cmp(t_rd, "bus_rdata", bus_rdata, e_rd);
            cmp(hi_io_en ? "R7" : "R6", "pin_oe[7:4]", {4'h0, pin_oe[7:4]}, {4'h0, e_oe[7:4]});
            cmp(hi_io_en ? "R7" : "R6", "pin_out[7:4]", {4'h0, pin_out[7:4]}, {4'h0, e_out[7:4]});
            cmp(lo_io_en ? "R9" : "R8", "pin_oe[3:0]", {4'h0, pin_oe[3:0]}, {4'h0, e_oe[3:0]});
            cmp(lo_io_en ? "R9" : "R8", "pin_out[3:0]", {4'h0, pin_out[3:0]}, {4'h0, e_out[3:0]});
            cmp("R6 R7", "ana_sel", ana_sel, e_ana);
        end
    end

    task automatic drive(input logic [1:0] a, input logic wr, input logic rd, input logic [7:0] wd);
        @(posedge clk); #2;
        bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = wd;
    endtask

    task automatic settle;
        @(negedge clk); #1;
    endtask

    initial begin
        rst = 1; bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
        hi_io_en = 0; lo_io_en = 0; ext_addr = 0; pin_in = 8'h00;
        repeat (3) @(posedge clk);
        #2 rst = 0;

        // R1 reset values
        drive(2'd2, 0, 1, 0); settle; cmp("R1", "dir after reset", bus_rdata, 8'hFF);
        drive(2'd1, 0, 1, 0); settle; cmp("R1", "latch after reset", bus_rdata, 8'h00);
        cmp("R6", "ana_sel default", ana_sel, 8'hF0);

        hi_io_en = 1; lo_io_en = 1;
        settle; cmp("R7 R9", "oe all inputs", pin_oe, 8'h00);

        // R2 write via port address then via latch address
        drive(2'd0, 1, 0, 8'hA5);
        drive(2'd1, 0, 1, 0); settle; cmp("R2", "latch via port addr", bus_rdata, 8'hA5);
        drive(2'd1, 1, 0, 8'h3C);
        drive(2'd1, 0, 1, 0); settle; cmp("R2", "latch via latch addr", bus_rdata, 8'h3C);

        // R3 direction
        drive(2'd2, 1, 0, 8'h0F);
        drive(2'd2, 0, 1, 0); settle; cmp("R3", "dir readback", bus_rdata, 8'h0F);
        cmp("R7 R9", "pin_oe from dir", pin_oe, 8'hF0);
        cmp("R7 R9", "pin_out from latch", pin_out, 8'h3C);

        // R4 / R5 pins differ from latch
        pin_in = 8'hC3;
        drive(2'd0, 0, 1, 0); settle;
        drive(2'd0, 0, 1, 0); settle;
        drive(2'd0, 0, 1, 0); settle; cmp("R5", "port read pins", bus_rdata, 8'hC3);
        drive(2'd1, 0, 1, 0); settle; cmp("R4", "latch not pins", bus_rdata, 8'h3C);

        // R8 / R10 bus mode
        lo_io_en = 0; ext_addr = 4'h9;
        drive(2'd1, 1, 0, 8'h71);
        drive(2'd2, 1, 0, 8'hF0);
        drive(2'd0, 0, 0, 0); settle;
        cmp("R8 R10", "bus drives ext", {4'h0, pin_out[3:0]}, 8'h09);
        cmp("R8", "bus oe", {4'h0, pin_oe[3:0]}, 8'h0F);
        lo_io_en = 1;
        settle; cmp("R10", "latch restored to pins", {4'h0, pin_out[3:0]}, 8'h01);
        cmp("R10", "dir restored to pins", {4'h0, pin_oe[3:0]}, 8'h0F);

        // R6 analog read-as-zero
        hi_io_en = 0; pin_in = 8'hFF;
        repeat (3) drive(2'd0, 0, 1, 0);
        settle; cmp("R6", "analog reads zero", bus_rdata, 8'h0F);

        // R11
        drive(2'd2, 0, 0, 0); settle; cmp("R11", "no read strobe", bus_rdata, 8'h00);
        drive(2'd3, 0, 1, 0); settle; cmp("R11", "unused address", bus_rdata, 8'h00);

        // randomized run
        for (int i = 0; i < 2000; i++) begin
            drive(2'($urandom), 1'($urandom), 1'($urandom), 8'($urandom));
            pin_in = 8'($urandom);
            ext_addr = 4'($urandom);
            if (($urandom % 8) == 0) hi_io_en = ~hi_io_en;
            if (($urandom % 8) == 0) lo_io_en = ~lo_io_en;
        end
        drive(2'd0, 0, 0, 0);
        settle;
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule